// File: doc/BRIEF.md
# Non-Repeating Random Replacement Index Generator

This block picks the victim slot for a random replacement policy in a small translation cache. A 32-bit linear congruential generator supplies pseudo-random bits. The upper half of each generator value is reduced into the window of replaceable slots. That window runs from the locked-entry boundary up to the top slot. A candidate that equals the index handed out last time is rejected, and the generator is advanced again until a different slot comes out.

The caller presents the slot count and the locked boundary and strobes a request. Some cycles later, a one-cycle valid flag marks the chosen index on the output. Each generator step and window reduction runs through a 16-step sequential divider. One attempt therefore costs a fixed number of cycles, and a rejected candidate adds one more attempt.

When only one slot is replaceable, that slot is returned on the next cycle and the generator is not advanced. A request whose window is empty is answered the same way, and it also raises an error flag.

Top module: `rig_top`

## Requirements
- R1: After reset, idx_o is 0 and valid_o and err_o are 0. The generator state is 1 and the remembered previous index is 0.
- R2: Each generator advance maps state s to (s * 1103515245 + 12345) mod 2^32.
- R3: For a window size n = entries_i - wired_i of at least 2, a candidate index is ((s >> 16) mod n) + wired_i, where s is the freshly advanced state.
- R4: A candidate equal to the previous index is rejected and the generator advances again. An index delivered from a window of at least 2 never equals the previous index.
- R5: When n = 1, idx_o = entries_i - 1 with valid_o high on the cycle after the request, and the generator state is left unchanged.
- R6: When wired_i >= entries_i, idx_o = (entries_i - 1) mod 2^IDX_W, with valid_o and err_o both high on the cycle after the request.
- R7: Every delivered index, including those from the R5 and R6 cases, becomes the previous index for the next request.
- R8: valid_o is high for exactly one cycle per accepted request. idx_o holds its value until the next delivery. err_o is high only together with valid_o.
- R9: A request raised while a draw is in progress is ignored. It produces no extra delivery and does not advance the generator.
- R10: A draw from a window of at least 2 delivers its index exactly 17 cycles per attempt after the request edge, where the attempts are the rejected candidates plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| entries_i | input | IDX_W+1 | Total slot count (1..2^IDX_W) |
| wired_i | input | IDX_W | First replaceable slot |
| idx_o | output | IDX_W | Chosen index |
| valid_o | output | 1 | One-cycle marker for a new idx_o |
| err_o | output | 1 | Empty window on the request just answered |

## Verification
The draw is tried over several windows: a full 16-slot window starting at 0, a 64-slot window, a 3-slot window offset by a locked boundary, and a 2-slot window. The 2-slot window is where a repeated candidate is likely, so it checks the retry path and the extra attempt latency separately from the plain reduction. A single-slot window placed directly after a normal draw shows that the generator is not advanced, because the next normal draw must still follow the reference sequence. An empty window, and a second strobe raised in the middle of a draw, check the error path and show that a busy request leaves no trace in later results.

// File: rtl/rig_pkg.sv
package rig_pkg;
  localparam int unsigned SEED_W = 32;
  localparam logic [SEED_W-1:0] LCG_MUL   = 32'd1103515245;
  localparam logic [SEED_W-1:0] LCG_INC   = 32'd12345;
  localparam logic [SEED_W-1:0] SEED_INIT = 32'd1;
  localparam int unsigned RND_W = 16;  // bits taken from the top of the state

  typedef enum logic {RIG_IDLE, RIG_DIV} rig_state_e;

  function automatic logic [SEED_W-1:0] lcg_step(input logic [SEED_W-1:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction
endpackage

// File: rtl/rig_lcg.sv
module rig_lcg
  import rig_pkg::*;
(
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_nx_o,
  output logic [RND_W-1:0]  rnd_o
);
  always_comb begin
    seed_nx_o = lcg_step(seed_i);
    rnd_o     = seed_nx_o[SEED_W-1 -: RND_W];
  end
endmodule

// File: rtl/rig_seq_mod.sv
// Restoring remainder, one numerator bit per cycle.
module rig_seq_mod #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [DEN_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W);

  logic [NUM_W-1:0] sh_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial, rem_nx;

  always_comb begin
    trial  = {rem_q, sh_q[NUM_W-1]};
    rem_nx = (trial >= {1'b0, den_q}) ? trial - {1'b0, den_q} : trial;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      sh_q   <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      sh_q  <= sh_q << 1;
      rem_q <= rem_nx[DEN_W-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/rig_top.sv
module rig_top
  import rig_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W:0]   entries_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam int unsigned ENT_W = IDX_W + 1;

  rig_state_e        state_q;
  logic [SEED_W-1:0] seed_q, seed_nx;
  logic [RND_W-1:0]  rnd;
  logic [IDX_W-1:0]  prev_q, idx_q, wir_q, last_idx, cand;
  logic [ENT_W-1:0]  rng_q, div_den, rem;
  logic [ENT_W:0]    diff;
  logic              win_bad, win_one, div_start, div_done, is_idle;
  logic              valid_q, err_q;

  rig_lcg u_lcg (
    .seed_i   (seed_q),
    .seed_nx_o(seed_nx),
    .rnd_o    (rnd)
  );

  always_comb begin
    is_idle  = (state_q == RIG_IDLE);
    diff     = {1'b0, entries_i} - {2'b0, wired_i};
    win_bad  = diff[ENT_W] || (diff == '0);
    win_one  = (diff == (ENT_W+1)'(1));
    last_idx = IDX_W'(entries_i - 1'b1);
    cand     = IDX_W'(wir_q + rem);
    div_den  = is_idle ? diff[ENT_W-1:0] : rng_q;
    div_start = (is_idle && req_i && !win_bad && !win_one) ||
                (!is_idle && div_done && cand == prev_q);
  end

  rig_seq_mod #(
    .NUM_W(RND_W),
    .DEN_W(ENT_W)
  ) u_mod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (rnd),
    .den_i  (div_den),
    .done_o (div_done),
    .rem_o  (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RIG_IDLE;
      seed_q  <= SEED_INIT;
      prev_q  <= '0;
      idx_q   <= '0;
      wir_q   <= '0;
      rng_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        RIG_IDLE: if (req_i) begin
          if (win_bad || win_one) begin
            idx_q   <= last_idx;
            prev_q  <= last_idx;
            valid_q <= 1'b1;
            err_q   <= win_bad;
          end else begin
            seed_q  <= seed_nx;
            wir_q   <= wired_i;
            rng_q   <= diff[ENT_W-1:0];
            state_q <= RIG_DIV;
          end
        end
        RIG_DIV: if (div_done) begin
          if (cand == prev_q) begin
            seed_q <= seed_nx;  // retry; divider restarted this cycle
          end else begin
            idx_q   <= cand;
            prev_q  <= cand;
            valid_q <= 1'b1;
            state_q <= RIG_IDLE;
          end
        end
        default: state_q <= RIG_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rig_chk.sv
module rig_chk
  import rig_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [IDX_W:0]   entries_i,
  input logic [IDX_W-1:0] wired_i,
  input logic [IDX_W-1:0] idx_o,
  input logic             valid_o,
  input logic             err_o,
  input logic             is_idle,
  input logic [SEED_W-1:0] seed_q
);
  logic [IDX_W:0]   lo_q, hi_q;
  logic [IDX_W-1:0] last_q;
  logic             multi_q;
  logic [IDX_W+1:0] win;

  assign win = {1'b0, entries_i} - {2'b0, wired_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      last_q  <= '0;
      multi_q <= 1'b0;
    end else begin
      if (is_idle && req_i) begin
        lo_q    <= {1'b0, wired_i};
        hi_q    <= entries_i;
        multi_q <= !win[IDX_W+1] && (win > (IDX_W+2)'(1));
      end
      if (valid_o) last_q <= idx_o;
    end
  end

  // R2
  seed_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_q != $past(seed_q)) |-> (seed_q == lcg_step($past(seed_q))));

  // R3
  idx_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && multi_q) |-> ({1'b0, idx_o} >= lo_q && {1'b0, idx_o} < hi_q));

  // R4
  no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && multi_q) |-> (idx_o != last_q));

  // R5
  single_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_idle && req_i && win == (IDX_W+2)'(1)) |=>
      (valid_o && !err_o && idx_o == IDX_W'($past(entries_i) - 1'b1) && $stable(seed_q)));

  // R6
  empty_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_idle && req_i && (win[IDX_W+1] || win == '0)) |=>
      (valid_o && err_o && idx_o == IDX_W'($past(entries_i) - 1'b1)));

  // R8
  err_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);

  // R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(idx_o));
endmodule

bind rig_top rig_chk #(.IDX_W(IDX_W)) u_rig_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .entries_i(entries_i),
  .wired_i  (wired_i),
  .idx_o    (idx_o),
  .valid_o  (valid_o),
  .err_o    (err_o),
  .is_idle  (is_idle),
  .seed_q   (seed_q)
);

// File: tb/test_rig_top.sv
module test_rig_top;
  localparam int unsigned IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic [IDX_W:0]   entries_i = '0;
  logic [IDX_W-1:0] wired_i = '0;
  logic [IDX_W-1:0] idx_o;
  logic             valid_o, err_o;

  int total = 0;
  int bad = 0;

  logic [31:0]      m_seed = 32'd1;
  logic [IDX_W-1:0] m_prev = '0;

  always #2 clk = ~clk;

  rig_top #(.IDX_W(IDX_W)) i_rig_top (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i),
    .entries_i(entries_i), .wired_i(wired_i),
    .idx_o(idx_o), .valid_o(valid_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: returns expected index, error flag and attempt count
  task automatic model(input int ent, input int wir,
                       output logic [IDX_W-1:0] e_idx, output logic e_err, output int tries);
    int n = ent - wir;
    tries = 0;
    e_err = 1'b0;
    if (n <= 1) begin
      e_idx = IDX_W'(ent - 1);
      e_err = (n <= 0);
    end else begin
      do begin
        m_seed = m_seed * 32'd1103515245 + 32'd12345;
        e_idx  = IDX_W'((m_seed >> 16) % n + wir);
        tries++;
      end while (e_idx == m_prev);
    end
    m_prev = e_idx;
  endtask

  task automatic draw(input int ent, input int wir, input string tag);
    logic [IDX_W-1:0] e_idx;
    logic e_err;
    int tries, k;
    model(ent, wir, e_idx, e_err, tries);
    @(negedge clk);
    entries_i = (IDX_W+1)'(ent);
    wired_i   = IDX_W'(wir);
    req_i     = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    k = 0;
    while (!valid_o && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check({tag, " idx"}, 32'(idx_o), 32'(e_idx));
    check({tag, " err"}, 32'(err_o), 32'(e_err));
    check({tag, " latency R10"}, k, 17 * tries);
    @(negedge clk);
    check({tag, " R8 one-cycle valid"}, 32'(valid_o), 0);
    check({tag, " R8 idx hold"}, 32'(idx_o), 32'(e_idx));
  endtask

  task automatic t_reset();
    check("R1 idx", 32'(idx_o), 0);
    check("R1 valid", 32'(valid_o), 0);
    check("R1 err", 32'(err_o), 0);
  endtask

  task automatic t_main();
    // first draw depends on state 1 and previous 0 after reset
    draw(16, 0, "R1 R2 R3 first");
    for (int i = 0; i < 5; i++) draw(16, 0, "R3 full16");
    for (int i = 0; i < 4; i++) draw(64, 0, "R3 full64");
    for (int i = 0; i < 6; i++) draw(8, 5, "R3 offset window");
  endtask

  task automatic t_retry();
    // 2-slot window: repeats are frequent, exercising rejection
    for (int i = 0; i < 12; i++) draw(8, 6, "R4 R7 two-slot");
  endtask

  task automatic t_single();
    draw(8, 7, "R5 single");
    draw(8, 6, "R5 R7 after single");  // prev is 7, seed untouched
    draw(4, 3, "R5 single small");
    draw(16, 2, "R5 seed untouched");
  endtask

  task automatic t_error();
    draw(4, 4, "R6 equal");
    draw(3, 10, "R6 below");
    draw(16, 0, "R6 R7 after error");
  endtask

  task automatic t_busy();
    logic [IDX_W-1:0] e_idx;
    logic e_err;
    int tries, seen;
    model(16, 0, e_idx, e_err, tries);
    @(negedge clk);
    entries_i = 7'd16; wired_i = '0; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (4) @(negedge clk);
    entries_i = 7'd8; wired_i = 6'd7; req_i = 1'b1;  // would be a single-slot draw
    @(negedge clk);
    req_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 17 * tries + 40; i++) begin
      if (valid_o) begin
        seen++;
        check("R9 busy idx", 32'(idx_o), 32'(e_idx));
      end
      @(negedge clk);
    end
    check("R9 single delivery", seen, 1);
    draw(16, 0, "R9 generator untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_main();
    t_retry();
    t_single();
    t_error();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule